// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block arbitrates among seven interrupt levels for a processor. Level 1 has the highest priority and level 7 the lowest. A level has a pending request when its software request bit is set or its device request input is high, and when its channel is switched on. The block grants the highest-priority pending level only if the system is switched on and that level outranks every level already in progress. On a grant it sets the in-progress bit of that level and pulses a grant with the level code. With the grant it also gives the dispatch address for a non-vectored interrupt, which is the base address plus 32 plus twice the level number.

Software controls the block through a command word. One command can clear the whole system, drop or raise software requests on the selected channels, switch channels on or off, and switch the whole system on or off. A command that has any must-be-zero bit set is rejected. After a grant, arbitration stays held off until the processor signals that the handoff is complete. A dismiss input frees the highest-priority level that is in progress. The full state can be read on a status word at any time.

Top module: `prio_irq_ctrl`

## Requirements
- R1: On synchronous reset, status reads all zero and grant_valid, cmd_reject are low.
- R2: A legal command with bit 7 (clear) set zeroes the on bit and all active, request and in-progress bits. The command's other actions are then applied on top of the cleared state in the same cycle.
- R3: In a legal command, bit 8 clears and bit 9 sets the software request bits of the channels selected in bits 6:0 (bit i is level i+1). When a command has both bits set, bit 9 wins.
- R4: In a legal command, bit 10 switches the system on and bit 11 switches it off. When a command has both bits set, the system ends up off.
- R5: In a legal command, bit 12 switches the selected channels on and bit 13 switches them off. When a command has both bits set, the channels end up off.
- R6: A command with any of bits 17:14 set is illegal. On the next cycle cmd_reject pulses for one cycle, and the on, active and request bits stay unchanged.
- R7: A request, whether from software or a device, can be granted only while its channel is on.
- R8: A grant is issued in a cycle that meets all of these conditions: the system is on, no handoff is pending and no command is being written. The level granted is the lowest-numbered pending level numbered below every in-progress level. One cycle later grant_valid pulses, grant_level carries the level 1..7, and that level's in-progress bit is set.
- R9: With each grant, dispatch_addr equals base_addr (as sampled in the granting cycle) + 32 + 2 × level.
- R10: After a grant, no further grant is issued until a handoff_done pulse is seen. handoff_done has no effect while no handoff is pending.
- R11: dismiss clears only the set in-progress bit with the lowest level number. With none set, dismiss changes nothing. A grant in the same cycle still sets its own bit.
- R12: Status layout: bits 6:0 are in-progress, 13:7 are software requests, 20:14 are the channel-on bits, and bit 21 is the system-on bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_word | input | 18 | Command word |
| dev_req | input | 7 | Device request lines, bit i = level i+1 |
| dismiss | input | 1 | Free highest-priority in-progress level |
| handoff_done | input | 1 | Processor finished taking the grant |
| base_addr | input | ADDR_W | Base for dispatch address |
| status | output | 22 | State readback |
| cmd_reject | output | 1 | Pulse: last command was illegal |
| grant_valid | output | 1 | Grant pulse |
| grant_level | output | 3 | Level granted, 1..7 |
| dispatch_addr | output | ADDR_W | Non-vectored dispatch address |

## Verification
Two pairs of functions can fall in the same cycle. A dismiss can meet a grant, and a command write can meet a grant that is otherwise ready. The directed part of the bench creates these overlaps on purpose. In random traffic, dismiss, handoff_done, device requests and commands hit the same cycles often. A bench model computes the state that the requirements predict after each edge. The bench compares that state against the full status word and the grant outputs every cycle. The comparison shows whether the dismissed bit and the newly granted bit were combined correctly, and whether a command write held the grant back.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NLVL  = 7;
    localparam int LVL_W = $clog2(NLVL + 1);
    localparam int MBZ_W = 4;

    // command word, MSB first
    typedef struct packed {
        logic [MBZ_W-1:0] mbz;
        logic             chan_off;
        logic             chan_on;
        logic             sys_off;
        logic             sys_on;
        logic             req_raise;
        logic             req_drop;
        logic             sys_clear;
        logic [NLVL-1:0]  sel;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef struct packed {
        logic            on;
        logic [NLVL-1:0] act;
        logic [NLVL-1:0] sw;
        logic [NLVL-1:0] ip;
    } irq_state_t;

    localparam int STAT_W = $bits(irq_state_t);

    function automatic logic [NLVL-1:0] lowest_bit(input logic [NLVL-1:0] v);
        return v & (~v + NLVL'(1));
    endfunction

    function automatic logic [LVL_W-1:0] level_of(input logic [NLVL-1:0] oh);
        logic [LVL_W-1:0] l;
        l = '0;
        for (int i = 0; i < NLVL; i++)
            if (oh[i]) l = LVL_W'(i + 1);
        return l;
    endfunction

endpackage

// File: rtl/prio_irq_dismiss.sv
module prio_irq_dismiss
    import prio_irq_pkg::*;
(
    input  logic [NLVL-1:0] ip_in,
    input  logic            dismiss,
    output logic [NLVL-1:0] ip_out
);
    logic [NLVL-1:0] top_bit;

    always_comb begin
        top_bit = lowest_bit(ip_in);
        ip_out  = dismiss ? (ip_in & ~top_bit) : ip_in;
    end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_irq_pkg::*;
(
    input  irq_state_t       st,
    input  logic [NLVL-1:0]  dev_req,
    input  logic             enable,
    output logic [NLVL-1:0]  gnt_oh,
    output logic [LVL_W-1:0] gnt_lvl,
    output logic             gnt_any
);
    logic [NLVL-1:0] pend;
    logic [NLVL-1:0] busy_cum;
    logic [NLVL-1:0] elig;

    assign busy_cum[0] = st.ip[0];
    for (genvar g = 1; g < NLVL; g++) begin : g_cum
        assign busy_cum[g] = busy_cum[g-1] | st.ip[g];
    end

    always_comb begin
        pend    = (st.sw | dev_req) & st.act;
        elig    = pend & ~busy_cum;
        gnt_oh  = enable ? lowest_bit(elig) : '0;
        gnt_any = |gnt_oh;
        gnt_lvl = level_of(gnt_oh);
    end
endmodule

// File: rtl/prio_irq_cmd.sv
module prio_irq_cmd
    import prio_irq_pkg::*;
(
    input  logic       cmd_valid,
    input  cmd_t       cmd,
    input  irq_state_t cur,
    output irq_state_t nxt,
    output logic       illegal
);
    logic legal;

    always_comb begin
        illegal = cmd_valid && (cmd.mbz != '0);
        legal   = cmd_valid && (cmd.mbz == '0);
        nxt     = cur;
        if (legal) begin
            if (cmd.sys_clear) nxt = '0;
            if (cmd.req_drop)  nxt.sw  = nxt.sw & ~cmd.sel;
            if (cmd.req_raise) nxt.sw  = nxt.sw | cmd.sel;
            if (cmd.sys_on)    nxt.on  = 1'b1;
            if (cmd.sys_off)   nxt.on  = 1'b0;
            if (cmd.chan_on)   nxt.act = nxt.act | cmd.sel;
            if (cmd.chan_off)  nxt.act = nxt.act & ~cmd.sel;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int VEC_OFS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic [NLVL-1:0]   dev_req,
    input  logic              dismiss,
    input  logic              handoff_done,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [STAT_W-1:0] status,
    output logic              cmd_reject,
    output logic              grant_valid,
    output logic [LVL_W-1:0]  grant_level,
    output logic [ADDR_W-1:0] dispatch_addr
);
    irq_state_t       st_q, st_evt, st_nxt;
    logic             hand_q;
    logic [NLVL-1:0]  ip_dis;
    logic [NLVL-1:0]  gnt_oh;
    logic [LVL_W-1:0] gnt_lvl;
    logic             gnt_any;
    logic             illegal;
    logic             arb_en;

    assign arb_en = st_q.on && !hand_q && !cmd_valid;

    prio_irq_dismiss u_dis (
        .ip_in  (st_q.ip),
        .dismiss(dismiss),
        .ip_out (ip_dis)
    );

    prio_irq_arbiter u_arb (
        .st     (st_q),
        .dev_req(dev_req),
        .enable (arb_en),
        .gnt_oh (gnt_oh),
        .gnt_lvl(gnt_lvl),
        .gnt_any(gnt_any)
    );

    always_comb begin
        st_evt    = st_q;
        st_evt.ip = ip_dis | gnt_oh;
    end

    prio_irq_cmd u_cmd (
        .cmd_valid(cmd_valid),
        .cmd      (cmd_t'(cmd_word)),
        .cur      (st_evt),
        .nxt      (st_nxt),
        .illegal  (illegal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= '0;
            hand_q        <= 1'b0;
            cmd_reject    <= 1'b0;
            grant_valid   <= 1'b0;
            grant_level   <= '0;
            dispatch_addr <= '0;
        end else begin
            st_q        <= st_nxt;
            cmd_reject  <= illegal;
            grant_valid <= gnt_any;
            if (gnt_any)
                hand_q <= 1'b1;
            else if (handoff_done)
                hand_q <= 1'b0;
            if (gnt_any) begin
                grant_level   <= gnt_lvl;
                dispatch_addr <= base_addr + ADDR_W'(VEC_OFS)
                               + ADDR_W'({gnt_lvl, 1'b0});
            end
        end
    end

    assign status = st_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import prio_irq_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int VEC_OFS = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              handoff_done,
    input logic [ADDR_W-1:0] base_addr,
    input logic [STAT_W-1:0] status,
    input logic              cmd_reject,
    input logic              grant_valid,
    input logic [LVL_W-1:0]  grant_level,
    input logic [ADDR_W-1:0] dispatch_addr
);
    logic            wait_h;
    logic [NLVL-1:0] lvl_oh, above;
    logic [NLVL-1:0] ip_v;

    assign ip_v = status[NLVL-1:0];

    always_comb begin
        for (int i = 0; i < NLVL; i++) begin
            lvl_oh[i] = (grant_level == LVL_W'(i + 1));
            above[i]  = (LVL_W'(i + 1) < grant_level);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wait_h <= 1'b0;
        else     wait_h <= (grant_valid | wait_h) & !handoff_done;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && !grant_valid && !cmd_reject)); // R1

    AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        cmd_reject |-> $stable(status[STAT_W-1:NLVL])); // R6

    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        grant_valid |=> !grant_valid); // R10

    AST_NO_GRANT_IN_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        wait_h |-> !grant_valid); // R10

    AST_GRANT_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (grant_level >= LVL_W'(1) && grant_level <= LVL_W'(NLVL))); // R8

    AST_GRANT_MARKS_IP: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((ip_v & lvl_oh) != '0)); // R8

    AST_GRANT_OUTRANKS: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> ((ip_v & above) == '0)); // R8

    AST_DISPATCH_ADDR: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> dispatch_addr == $past(base_addr) + ADDR_W'(VEC_OFS)
                                         + ADDR_W'({grant_level, 1'b0})); // R9
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_OFS(VEC_OFS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .handoff_done (handoff_done),
    .base_addr    (base_addr),
    .status       (status),
    .cmd_reject   (cmd_reject),
    .grant_valid  (grant_valid),
    .grant_level  (grant_level),
    .dispatch_addr(dispatch_addr)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    import prio_irq_pkg::*;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 18;
    localparam int VOFS   = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              cmd_valid;
    logic [CMD_W-1:0]  cmd_word;
    logic [NLVL-1:0]   dev_req;
    logic              dismiss;
    logic              handoff_done;
    logic [ADDR_W-1:0] base_addr;
    logic [STAT_W-1:0] status;
    logic              cmd_reject;
    logic              grant_valid;
    logic [LVL_W-1:0]  grant_level;
    logic [ADDR_W-1:0] dispatch_addr;

    int vectors = 0;
    int errs    = 0;
    bit done    = 0;

    // bench model
    logic        m_on, m_hand, m_gv, m_rej;
    logic [6:0]  m_act, m_sw, m_ip;
    logic [2:0]  m_lvl;
    logic [17:0] m_addr;

    always #(CLK_P/2) clk = ~clk;

    prio_irq_ctrl #(.ADDR_W(ADDR_W), .VEC_OFS(VOFS)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .dev_req(dev_req), .dismiss(dismiss), .handoff_done(handoff_done),
        .base_addr(base_addr), .status(status), .cmd_reject(cmd_reject),
        .grant_valid(grant_valid), .grant_level(grant_level),
        .dispatch_addr(dispatch_addr)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] m_status();
        return {m_on, m_act, m_sw, m_ip};
    endfunction

    task automatic step(input logic cv, input logic [17:0] cw, input logic [6:0] dr,
                        input logic dis, input logic hd, input logic [17:0] base);
        logic [6:0] pend, g, ip_n, sw_n, act_n, sel;
        logic       on_n, blk, legal;
        @(negedge clk);
        cmd_valid = cv; cmd_word = cw; dev_req = dr; dismiss = dis;
        handoff_done = hd; base_addr = base;
        // expected next state from the requirements
        pend = (m_sw | dr) & m_act;
        g = '0; blk = 0;
        for (int i = 0; i < 7; i++) begin
            if (m_ip[i]) blk = 1;
            if (!blk && pend[i] && g == 0) g[i] = 1'b1;
        end
        if (!(m_on && !m_hand && !cv)) g = '0;
        ip_n = m_ip;
        if (dis) for (int i = 0; i < 7; i++) if (ip_n[i]) begin ip_n[i] = 1'b0; break; end
        ip_n = ip_n | g;
        sw_n = m_sw; act_n = m_act; on_n = m_on; sel = cw[6:0];
        legal = cv && (cw[17:14] == 0);
        if (legal) begin
            if (cw[7]) begin sw_n = 0; act_n = 0; on_n = 0; ip_n = 0; end
            if (cw[8])  sw_n  = sw_n & ~sel;
            if (cw[9])  sw_n  = sw_n | sel;
            if (cw[10]) on_n  = 1'b1;
            if (cw[11]) on_n  = 1'b0;
            if (cw[12]) act_n = act_n | sel;
            if (cw[13]) act_n = act_n & ~sel;
        end
        @(posedge clk);
        #1;
        m_rej = cv && !legal;
        m_gv  = (g != 0);
        if (m_gv) begin
            for (int i = 0; i < 7; i++) if (g[i]) m_lvl = 3'(i + 1);
            m_addr = base + 18'(VOFS) + 18'({m_lvl, 1'b0});
            m_hand = 1'b1;
        end else if (hd) m_hand = 1'b0;
        m_on = on_n; m_act = act_n; m_sw = sw_n; m_ip = ip_n;
        vectors++;
        cmp("R2/R3/R4/R5/R11/R12 status", int'(status), int'(m_status()));
        cmp("R6 cmd_reject", int'(cmd_reject), int'(m_rej));
        cmp("R7/R8/R10 grant_valid", int'(grant_valid), int'(m_gv));
        if (m_gv) begin
            cmp("R8 grant_level", int'(grant_level), int'(m_lvl));
            cmp("R9 dispatch_addr", int'(dispatch_addr), int'(m_addr));
        end
    endtask

    task automatic idle(input logic [6:0] dr, input logic hd);
        step(1'b0, 18'h0, dr, 1'b0, hd, 18'd100);
    endtask

    task automatic cmd(input logic [17:0] cw, input logic dis);
        step(1'b1, cw, 7'h0, dis, 1'b0, 18'd100);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1977));
        rst = 1; cmd_valid = 0; cmd_word = 0; dev_req = 0; dismiss = 0;
        handoff_done = 0; base_addr = 0;
        m_on = 0; m_hand = 0; m_gv = 0; m_rej = 0; m_act = 0; m_sw = 0; m_ip = 0;
        m_lvl = 0; m_addr = 0;
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        cmp("R1 reset status", int'(status), 0);
        cmp("R1 reset grant", int'(grant_valid), 0);
        cmp("R1 reset reject", int'(cmd_reject), 0);
        @(negedge clk); rst = 0;

        cmd(18'h0147F | (18'h1 << 10), 1'b0);     // all channels on, system on
        cmp("R4/R5 enable", int'(status), int'((22'h1 << 21) | (22'h7F << 14)));
        cmd((18'h1 << 9) | 18'h14, 1'b0);          // raise levels 3 and 5 (grant held)
        cmp("R8 no grant while writing", int'(grant_valid), 0);
        idle(7'h0, 1'b0);
        cmp("R8 grant level 3", int'(grant_level), 3);
        cmp("R9 dispatch 100+32+6", int'(dispatch_addr), 138);
        idle(7'h0, 1'b0);
        cmp("R10 held in handoff", int'(grant_valid), 0);
        idle(7'h0, 1'b1);
        idle(7'h0, 1'b0);
        cmp("R8 level 5 below in-progress 3", int'(grant_valid), 0);
        cmd((18'h1 << 9) | 18'h01, 1'b0);          // raise level 1
        idle(7'h0, 1'b0);
        cmp("R8 grant level 1", int'(grant_level), 1);
        cmp("R9 dispatch 100+32+2", int'(dispatch_addr), 134);
        idle(7'h0, 1'b1);
        step(1'b0, 18'h0, 7'h0, 1'b1, 1'b0, 18'd100);  // dismiss
        cmp("R11 dismiss frees level 1 only", int'(status[6:0]), 4);
        cmd((18'h1 << 14) | (18'h1 << 7), 1'b0);   // illegal clear
        cmp("R6 reject pulse", int'(cmd_reject), 1);
        cmp("R6 state kept", int'(status[6:0]), 4);
        cmd((18'h1 << 8) | 18'h7F, 1'b1);          // drop all, dismiss level 3
        cmp("R11 dismiss last", int'(status[6:0]), 0);
        cmd((18'h1 << 13) | 18'h02, 1'b0);         // level 2 channel off
        idle(7'h02, 1'b0);
        idle(7'h02, 1'b0);
        cmp("R7 device request on closed channel", int'(grant_valid), 0);
        cmd((18'h3 << 8) | 18'h08, 1'b0);          // drop+raise level 4
        cmp("R3 raise wins", int'(status[13:7]), 8);
        cmd(18'h3 << 10, 1'b0);                    // on+off
        cmp("R4 off wins", int'(status[21]), 0);
        cmd((18'h1 << 7) | (18'h1 << 9) | 18'h01, 1'b0);
        cmp("R2 clear then raise", int'(status), int'(22'h1 << 7));
        cmd((18'h3 << 12) | 18'h10, 1'b0);         // chan on+off
        cmp("R5 off wins", int'(status[20:14]), 0);
        cmd((18'h1 << 12) | (18'h1 << 10) | 18'h7F, 1'b0);

        for (int n = 0; n < 4000; n++) begin
            logic [17:0] cw;
            logic        cv;
            cw = 18'($urandom);
            if ($urandom % 8 != 0) cw[17:14] = 0;
            if ($urandom % 10 != 0) cw[7] = 0;
            if ($urandom % 4 != 0) cw[11] = 0;
            cv = ($urandom % 5 == 0);
            step(cv, cw, ($urandom % 3 == 0) ? 7'($urandom) : 7'h0,
                 ($urandom % 5 == 0), ($urandom % 3 == 0), 18'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule